// File: doc/BRIEF.md
# Segmented Current-Steering DAC Code Decoder

This block turns a binary sample word into the individual switch controls of a segmented current-steering DAC core. The incoming code is split into three fields. The top field drives a bank of equal-weight unit cells in thermometer form. The middle field drives a second, finer thermometer bank. The bottom bits drive binary-weighted cells directly.

The block has two register stages. The first stage captures the code on the sample clock. The second stage re-times every decoded switch line in one wide register, so all cells move on the same edge. Each switch line has a complement, so the current can be steered to either side of a differential output. The complement lines come from the same register stage as the true lines.

With the default widths (5 + 4 + 5 = 14 bits), the outputs are 31 upper enables of 512 LSB each, 15 middle enables of 32 LSB each and 5 binary enables.

Top module: `seg_dac_decoder`

## Requirements
- R1: An output reflects the `code_i` sampled two rising clock edges earlier. After the first of those two edges the outputs still show the earlier code.
- R2: The upper field is `code_i[13:9]`, with value v. `msb_en_o[i]` is 1 exactly when v > i, for i in 0..30. Each of these enables weighs 512 LSB.
- R3: The middle field is `code_i[8:5]`, with value m. `mid_en_o[i]` is 1 exactly when m > i, for i in 0..14. Each of these enables weighs 32 LSB.
- R4: `lsb_en_o[b]` equals `code_i[b]` for b in 0..4. Bit b weighs 2^b LSB.
- R5: For every one of the 16384 codes, the summed weight of all asserted enables equals the code.
- R6: In every cycle, each `*_enb_o` line is the bitwise inverse of its `*_en_o` line.
- R7: While `rst_ni` is low, every enable reads 0 and every complement reads 1, with no clock edge needed. The first code is captured on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 14 | Binary DAC code |
| msb_en_o | output | 31 | Upper thermometer enables, 512 LSB each |
| mid_en_o | output | 15 | Middle thermometer enables, 32 LSB each |
| lsb_en_o | output | 5 | Binary enables, 2^b LSB |
| msb_enb_o | output | 31 | Complement of msb_en_o |
| mid_enb_o | output | 15 | Complement of mid_en_o |
| lsb_enb_o | output | 5 | Complement of lsb_en_o |

## Verification
Every decoded line is due on the second rising edge after its code is presented. The sweep drives a new code on each falling edge and checks, on the falling edge two cycles later, the code driven two iterations before. One code enters the pipe every cycle, and each result is matched against the code that produced it. A separate check holds a full-scale code behind a zero code and samples after one edge and again after two edges, to confirm the outputs do not move early. A reset is asserted asynchronously in the middle of traffic, and the outputs are sampled before any further edge.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int unsigned DEF_MSB_W = 5;
  localparam int unsigned DEF_MID_W = 4;
  localparam int unsigned DEF_LSB_W = 5;

  function automatic int unsigned therm_lines(int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/therm_dec.sv
module therm_dec #(
  parameter int unsigned VAL_W = 4,
  localparam int unsigned N = (1 << VAL_W) - 1
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [N-1:0]     therm_o
);
  // line i is on for every value above i: fills from bit 0 upward
  for (genvar i = 0; i < N; i++) begin : g_line
    assign therm_o[i] = (val_i > VAL_W'(i));
  end
endmodule

// File: rtl/sw_latch.sv
module sw_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] qn_o
);
  // true and complement held in separate flops on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o  <= '0;
      qn_o <= '1;
    end else begin
      q_o  <= d_i;
      qn_o <= ~d_i;
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int unsigned MSB_W = DEF_MSB_W,
  parameter int unsigned MID_W = DEF_MID_W,
  parameter int unsigned LSB_W = DEF_LSB_W,
  localparam int unsigned CODE_W = MSB_W + MID_W + LSB_W,
  localparam int unsigned MSB_N  = (1 << MSB_W) - 1,
  localparam int unsigned MID_N  = (1 << MID_W) - 1,
  localparam int unsigned SW_W   = MSB_N + MID_N + LSB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [MSB_N-1:0]  msb_en_o,
  output logic [MID_N-1:0]  mid_en_o,
  output logic [LSB_W-1:0]  lsb_en_o,
  output logic [MSB_N-1:0]  msb_enb_o,
  output logic [MID_N-1:0]  mid_enb_o,
  output logic [LSB_W-1:0]  lsb_enb_o
);
  localparam int unsigned MID_WT = 1 << LSB_W;
  localparam int unsigned MSB_WT = 1 << (LSB_W + MID_W);

  logic [CODE_W-1:0] code_q;
  logic [MSB_N-1:0]  msb_t;
  logic [MID_N-1:0]  mid_t;
  logic [SW_W-1:0]   sw_d, sw_q, sw_qn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_i;
  end

  therm_dec #(.VAL_W(MSB_W)) u_msb_dec (
    .val_i   (code_q[CODE_W-1 -: MSB_W]),
    .therm_o (msb_t)
  );

  therm_dec #(.VAL_W(MID_W)) u_mid_dec (
    .val_i   (code_q[LSB_W +: MID_W]),
    .therm_o (mid_t)
  );

  assign sw_d = {msb_t, mid_t, code_q[LSB_W-1:0]};

  sw_latch #(.W(SW_W)) u_sw_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sw_d),
    .q_o    (sw_q),
    .qn_o   (sw_qn)
  );

  assign lsb_en_o  = sw_q[LSB_W-1:0];
  assign mid_en_o  = sw_q[LSB_W +: MID_N];
  assign msb_en_o  = sw_q[SW_W-1 -: MSB_N];
  assign lsb_enb_o = sw_qn[LSB_W-1:0];
  assign mid_enb_o = sw_qn[LSB_W +: MID_N];
  assign msb_enb_o = sw_qn[SW_W-1 -: MSB_N];

  p_weight_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(msb_en_o) * MSB_WT + $countones(mid_en_o) * MID_WT
     + int'(lsb_en_o)) == int'($past(code_q)));

  p_msb_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((msb_en_o + 1'b1) & msb_en_o) == '0);

  p_mid_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mid_en_o + 1'b1) & mid_en_o) == '0);

  p_lsb_direct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsb_en_o == $past(code_q[LSB_W-1:0]));

  p_complement_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&(msb_en_o ^ msb_enb_o)) && (&(mid_en_o ^ mid_enb_o))
    && (&(lsb_en_o ^ lsb_enb_o)));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(code_q) |=> $stable(sw_q));
endmodule

// File: tb/tb_seg_dac_decoder.sv
`timescale 1ns/1ps
module tb_seg_dac_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] code_i = '0;
  logic [30:0] msb_en_o, msb_enb_o;
  logic [14:0] mid_en_o, mid_enb_o;
  logic [4:0]  lsb_en_o, lsb_enb_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_dac_decoder dut (
    .clk_i, .rst_ni, .code_i,
    .msb_en_o, .mid_en_o, .lsb_en_o,
    .msb_enb_o, .mid_enb_o, .lsb_enb_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_code(input int c);
    logic [30:0] em;
    logic [14:0] ed;
    int sum;
    for (int j = 0; j < 31; j++) em[j] = ((c >> 9) > j);
    for (int j = 0; j < 15; j++) ed[j] = (((c >> 5) & 15) > j);
    chk(msb_en_o == em, "R2", "msb", msb_en_o, em);
    chk(mid_en_o == ed, "R3", "mid", mid_en_o, ed);
    chk(lsb_en_o == 5'(c & 31), "R4", "lsb", lsb_en_o, c & 31);
    sum = $countones(msb_en_o) * 512 + $countones(mid_en_o) * 32;
    for (int b = 0; b < 5; b++) if (lsb_en_o[b]) sum += (1 << b);
    chk(sum == c, "R5", "weight", sum, c);
    chk((msb_enb_o == ~msb_en_o) && (mid_enb_o == ~mid_en_o)
        && (lsb_enb_o == ~lsb_en_o), "R6", "complement",
        {msb_enb_o, mid_enb_o, lsb_enb_o}, ~{msb_en_o, mid_en_o, lsb_en_o});
  endtask

  task automatic check_reset_state(input string what);
    chk(msb_en_o == '0 && mid_en_o == '0 && lsb_en_o == '0, "R7",
        {what, " enables"}, {msb_en_o, mid_en_o, lsb_en_o}, 0);
    chk(&{msb_enb_o, mid_enb_o, lsb_enb_o}, "R7", {what, " complements"},
        {msb_enb_o, mid_enb_o, lsb_enb_o}, 51'h7_FFFF_FFFF_FFFF);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "WD", "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    code_i = 14'h3FFF;
    repeat (3) @(negedge clk_i);
    check_reset_state("during reset");
    code_i = '0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: latency of two edges
    code_i = 14'h3FFF;
    @(negedge clk_i);
    check_code(0);
    chk(msb_en_o == '0, "R1", "no early update", msb_en_o, 0);
    @(negedge clk_i);
    check_code(16383);
    chk(msb_en_o == '1, "R1", "update after two edges", msb_en_o, 31'h7FFF_FFFF);

    // exhaustive pipelined sweep
    for (int i = 0; i < 16386; i++) begin
      @(negedge clk_i);
      if (i >= 2) check_code(i - 2);
      if (i < 16384) code_i = 14'(i);
    end

    // R7: asynchronous reset in traffic
    code_i = 14'h2A5B;
    repeat (3) @(negedge clk_i);
    check_code(14'h2A5B);
    #1 rst_ni = 1'b0;
    #0.5;
    check_reset_state("async assert");
    @(negedge clk_i);
    rst_ni = 1'b1;
    code_i = 14'h1234;
    @(negedge clk_i);
    check_reset_state("first edge after release");
    @(negedge clk_i);
    check_code(14'h1234);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule